// File: doc/BRIEF.md
# Five-Word Sequence Lock

The block is a lock controller. It takes one 8-bit code word on every rising clock edge, along with a marker bit that flags the opening word of a five-word attempt. Each attempt is compared word by word against a fixed secret sequence set by a parameter. When the fifth word arrives, the block reports the verdict on two registered flags. `unlock` goes high for a full match. `warning` goes high for any mismatch. A mismatch early in the attempt does not end it: the block still takes in the remaining words and gives its verdict only at the frame's last edge.

Failed attempts are counted, and a successful attempt sets the count back to zero. A third failure puts the block into a sticky lockout. Lockout also happens at once if the marker is raised on any word other than the first of a frame. In lockout the block holds `unlock` low and `warning` high until the asynchronous active-low reset is applied. Between frames the block waits for the marker, and it ignores words that arrive without it. The data path has no valid/ready handshake because the block never stalls. A word is consumed on every edge, and the source must present a word whenever it raises the marker.

Top module: `seq_lock`

## Requirements
- R1: While idle, a word sampled with `first`=1 opens a frame. The next four edges each consume exactly one further word, with no stall.
- R2: The secret sequence is 36, 19, 56, 101, 73 in order. When all five words match, `unlock`=1 and `warning`=0 are visible right after the edge that samples the fifth word.
- R3: When any word of a frame mismatches, `unlock`=0 and `warning`=1 are visible right after the fifth word's edge and not before. The words after the mismatch are still consumed.
- R4: `unlock` and `warning` are registered. They hold their values on every edge that does not complete a frame or enter lockout.
- R5: While idle, words sampled with `first`=0 are ignored. They change no output and do not count as failures.
- R6: If `first`=1 is sampled on word positions 2 to 5 of a frame, the block enters lockout on that same edge.
- R7: Each failed frame increments a failure count. The third failure enters lockout on its fifth-word edge.
- R8: A fully matching frame clears the failure count to zero.
- R9: In lockout, `unlock`=0 and `warning`=1 are held whatever the inputs are, until reset.
- R10: `rst_n`=0 asynchronously forces `unlock`=0 and `warning`=0, returns the block to idle and clears the failure count.
- R11: A new frame may open on the edge right after the previous frame's fifth word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| num_in | input | 8 | Code word sampled every edge |
| first | input | 1 | Marks the opening word of a frame |
| unlock | output | 1 | Last frame fully matched |
| warning | output | 1 | Last frame failed, or block is in lockout |

## Verification
The assertions assume that `num_in` and `first` are stable around each rising edge, and that reset is released only between edges. The bench drives both inputs on the falling edge and applies reset at a falling edge, then releases it at a later one, so it keeps within these assumptions. The assertions allow any pattern on the marker, including illegal ones, because lockout is itself checked behaviour. The random stimulus therefore deliberately mixes frames with misplaced markers, idle gaps, partial matches and back-to-back frames. It applies reset whenever the bench's model reaches lockout.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LOCK  = 2'd2
  } lock_state_e;

  // Per-edge events decided by the frame controller
  typedef struct packed {
    logic done;     // fifth word consumed this edge
    logic pass;     // whole frame matched (valid with done)
    logic violate;  // marker seen inside a frame
    logic go_lock;  // entering lockout this edge
  } frame_evt_t;

endpackage

// File: rtl/seq_lock_code_sel.sv
module seq_lock_code_sel #(
  parameter int WORD_W    = 8,
  parameter int FRAME_LEN = 5,
  parameter int IDX_W     = 3,
  parameter logic [FRAME_LEN-1:0][WORD_W-1:0] SECRET = '0
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] expected
);

  // Select the secret word for the current frame position
  always_comb begin
    expected = '0;
    for (int i = 0; i < FRAME_LEN; i++) begin
      if (idx == IDX_W'(i)) expected = SECRET[i];
    end
  end

endmodule

// File: rtl/seq_lock_fsm.sv
module seq_lock_fsm
  import seq_lock_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int FRAME_LEN = 5,
  parameter int IDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              first,
  input  logic [WORD_W-1:0] expected,
  input  logic              limit_hit,
  output logic [IDX_W-1:0]  idx_sel,
  output frame_evt_t        evt,
  output logic              busy,
  output logic              locked
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  lock_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             mis_q, mis_d;
  logic             word_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mis_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      mis_q   <= mis_d;
    end
  end

  assign idx_sel  = (state_q == ST_CHECK) ? idx_q : '0;
  assign word_bad = (word != expected);
  assign busy     = (state_q == ST_CHECK);
  assign locked   = (state_q == ST_LOCK);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    mis_d   = mis_q;
    evt     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (first) begin
          state_d = ST_CHECK;
          idx_d   = IDX_W'(1);
          mis_d   = word_bad;
        end
      end
      ST_CHECK: begin
        if (first) begin
          evt.violate = 1'b1;
          evt.go_lock = 1'b1;
          state_d     = ST_LOCK;
          idx_d       = '0;
          mis_d       = 1'b0;
        end else if (idx_q == LAST_IDX) begin
          evt.done = 1'b1;
          evt.pass = !(mis_q || word_bad);
          idx_d    = '0;
          mis_d    = 1'b0;
          if (!evt.pass && limit_hit) begin
            evt.go_lock = 1'b1;
            state_d     = ST_LOCK;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          idx_d = idx_q + IDX_W'(1);
          mis_d = mis_q || word_bad;
        end
      end
      ST_LOCK: begin
        state_d = ST_LOCK;
      end
      default: begin
        state_d = ST_IDLE;
        idx_d   = '0;
        mis_d   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/seq_lock_fail_ctr.sv
module seq_lock_fail_ctr #(
  parameter int MAX_FAIL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic pass,
  output logic limit_hit
);

  localparam int CNT_W = $clog2(MAX_FAIL + 1);
  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(MAX_FAIL - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (done) begin
      if (pass)                   cnt_q <= '0;
      else if (cnt_q != LIMIT_M1) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // Next failure is the one that trips lockout
  assign limit_hit = (cnt_q == LIMIT_M1);

endmodule

// File: rtl/seq_lock_out_reg.sv
module seq_lock_out_reg
  import seq_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  frame_evt_t evt,
  output logic       unlock,
  output logic       warning
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock  <= 1'b0;
      warning <= 1'b0;
    end else if (evt.go_lock) begin
      unlock  <= 1'b0;
      warning <= 1'b1;
    end else if (evt.done) begin
      unlock  <= evt.pass;
      warning <= !evt.pass;
    end
  end

endmodule

// File: rtl/seq_lock.sv
module seq_lock
  import seq_lock_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int FRAME_LEN = 5,
  parameter int MAX_FAIL  = 3,
  parameter logic [FRAME_LEN-1:0][WORD_W-1:0] SECRET =
    {8'd73, 8'd101, 8'd56, 8'd19, 8'd36}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] num_in,
  input  logic              first,
  output logic              unlock,
  output logic              warning
);

  localparam int IDX_W = $clog2(FRAME_LEN);

  logic [IDX_W-1:0]  idx_sel;
  logic [WORD_W-1:0] expected;
  logic              limit_hit;
  frame_evt_t        evt;
  logic              fsm_busy;
  logic              fsm_locked;

  seq_lock_code_sel #(
    .WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W), .SECRET(SECRET)
  ) u_code (
    .idx(idx_sel), .expected(expected)
  );

  seq_lock_fsm #(
    .WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .word(num_in), .first(first),
    .expected(expected), .limit_hit(limit_hit), .idx_sel(idx_sel),
    .evt(evt), .busy(fsm_busy), .locked(fsm_locked)
  );

  seq_lock_fail_ctr #(.MAX_FAIL(MAX_FAIL)) u_fail (
    .clk(clk), .rst_n(rst_n), .done(evt.done), .pass(evt.pass),
    .limit_hit(limit_hit)
  );

  seq_lock_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .evt(evt), .unlock(unlock), .warning(warning)
  );

endmodule

// File: rtl/seq_lock_chk.sv
module seq_lock_chk #(
  parameter int WORD_W    = 8,
  parameter int FRAME_LEN = 5,
  parameter logic [FRAME_LEN-1:0][WORD_W-1:0] SECRET = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] num_in,
  input logic              first,
  input logic              unlock,
  input logic              warning,
  input logic              busy,
  input logic              locked
);

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!unlock && !warning);
    end
  end

  // R2
  unlock_needs_last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock) |-> ($past(num_in) == SECRET[FRAME_LEN-1]) && !$past(first) && $past(busy));

  // R3
  warning_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warning) |-> $past(busy));

  // R4
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(unlock && warning));

  // R5
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !locked && !first) |=> $stable(unlock) && $stable(warning));

  // R6
  marker_violation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && first) |=> locked && warning && !unlock);

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && warning && !unlock);

endmodule

bind seq_lock seq_lock_chk #(
  .WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN), .SECRET(SECRET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .num_in(num_in), .first(first),
  .unlock(unlock), .warning(warning), .busy(fsm_busy), .locked(fsm_locked)
);

// File: tb/tb_seq_lock.sv
`timescale 1ns/1ps
module tb_seq_lock;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] num_in = '0;
  logic       first = 1'b0;
  logic       unlock, warning;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] sec [5] = '{8'd36, 8'd19, 8'd56, 8'd101, 8'd73};

  // reference model state
  int pos = -1;
  bit bad_w, lk, exp_u, exp_w;
  int fails;

  seq_lock dut (.clk(clk), .rst_n(rst_n), .num_in(num_in), .first(first),
                .unlock(unlock), .warning(warning));

  always #5 clk = ~clk;

  function automatic void model_reset();
    pos = -1; bad_w = 0; lk = 0; exp_u = 0; exp_w = 0; fails = 0;
  endfunction

  function automatic void model_edge(logic [7:0] w, logic f);
    if (lk) return;
    if (pos < 0) begin
      if (f) begin pos = 1; bad_w = (w != sec[0]); end
    end else if (f) begin
      lk = 1; exp_u = 0; exp_w = 1; pos = -1;
    end else begin
      bad_w = bad_w | (w != sec[pos]);
      if (pos == 4) begin
        if (!bad_w) begin exp_u = 1; exp_w = 0; fails = 0; end
        else begin
          exp_u = 0; exp_w = 1; fails++;
          if (fails >= 3) lk = 1;
        end
        pos = -1;
      end else pos++;
    end
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (unlock !== exp_u || warning !== exp_w) begin
      n_bad++;
      $display("FAIL %s: unlock/warning = %b%b expected %b%b at %0t",
               tag, unlock, warning, exp_u, exp_w, $time);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking
  task automatic step(logic [7:0] w, logic f, string tag);
    num_in = w; first = f;
    @(posedge clk);
    model_edge(w, f);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset(string tag);
    rst_n = 0; first = 0;
    #1;
    model_reset();
    check(tag);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(tag);
  endtask

  // mode: 0 correct, 1 one bad word at bad_pos, 2 marker at bad_pos
  task automatic frame(int mode, int bad_pos, string tag);
    for (int i = 0; i < 5; i++) begin
      logic [7:0] w = sec[i];
      logic f = (i == 0);
      if (mode == 1 && i == bad_pos) w = sec[i] ^ 8'(1 + $urandom % 255);
      if (mode == 2 && i == bad_pos) f = 1;
      step(w, f, tag);
      if (mode == 2 && i == bad_pos) return;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    @(negedge clk);
    check("R10");
    do_reset("R10");
    // R2 / R1: correct frame
    frame(0, 0, "R2");
    // R4: holds while idle
    step(8'd0, 0, "R4");
    // R3: mismatch on word 1, verdict only at end
    frame(1, 0, "R3");
    // R11: back-to-back correct frame, R8 clears count
    frame(0, 0, "R11");
    // R5: idle words without marker ignored, even the correct first word
    step(8'd36, 0, "R5");
    step(8'd99, 0, "R5");
    // R8: fail, fail, pass, fail, fail -> no lock
    frame(1, 4, "R8"); frame(1, 2, "R8"); frame(0, 0, "R8");
    frame(1, 1, "R8"); frame(1, 3, "R8");
    frame(0, 0, "R8");
    // R7: three failures in a row
    frame(1, 0, "R7"); frame(1, 4, "R7"); frame(1, 2, "R7");
    // R9: correct frame in lockout has no effect
    frame(0, 0, "R9");
    step(8'd0, 1, "R9");
    do_reset("R10");
    // R6: marker on word 3
    frame(2, 2, "R6");
    step(8'd36, 1, "R9");
    do_reset("R10");
    // R10: reset mid-frame, then a clean pass
    step(sec[0], 1, "R1"); step(sec[1], 0, "R1");
    do_reset("R10");
    frame(0, 0, "R10");
    // random phase
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 10;
      if (lk) begin
        frame(0, 0, "R9");
        do_reset("R10");
      end else if (r < 4) frame(0, 0, "R2");
      else if (r < 7) frame(1, $urandom % 5, "R3");
      else if (r == 7) frame(2, 1 + $urandom % 4, "R6");
      else begin
        int k = 1 + $urandom % 3;
        for (int j = 0; j < k; j++) step(8'($urandom), 0, "R5");
      end
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule